// File: doc/BRIEF.md
# Descriptor-chained DMA channel engine

One DMA channel that copies a run of elements from a source region to a destination region over a simple request/grant memory master. Software writes a 32-bit transfer-configuration word. The source end address, the destination end address and the link word come from a four-word descriptor in memory. The engine works out each start address from the stored end address, the element width, the stride and the count. It then moves elements one at a time, one read and one write for each element. When the reload bit is set, it fetches the next descriptor from the link address and carries on.

A side held at a fixed address (increment code 0) is treated as a peripheral data register. Each element on that side waits for the peripheral request input. Software stops a channel in three steps: it clears the enable, waits for busy to fall, then writes abort. On completion the engine raises interrupt flags A and B as the descriptor selects. A bus error raises an error flag and stops the channel. Software clears all three flags by writing ones.

Top module: `dma_chan_engine`

## Requirements
- R1: A write to select 1 (configuration word) while the channel is inactive loads the word. If bit0 (valid) and bit2 (software start) are both set, active_o is high from the next cycle. If either bit is clear, the word is stored and the channel stays inactive. The word layout is: bit1 reload, bit4 flag A, bit5 flag B, [9:8] width, [13:12] source increment, [15:14] destination increment, [25:16] count.
- R2: On a software start the engine reads three words from the table base (select 2, aligned down to 16 bytes): source end at base+4, destination end at base+8, link at base+12. On a reload it reads four words from the link address: the configuration at +0, then the same three words. All these reads use size code 2.
- R3: Increment codes 0, 1, 2 and 3 mean 0, 1, 2 and 4 elements. The stride in bytes is the increment times the element size. The first address on each side is the end address minus stride×count, and each following element adds the stride.
- R4: Width codes 0, 1 and 2 mean 1, 2 and 4 bytes. mem_size_o carries the width code during element reads and writes. Write data is the read data with every bit above the element size cleared.
- R5: cfg_o[25:16] reads back as the number of remaining elements minus one. After the last element it reads 0x3FF, and with active_o low that means the transfer is finished. The maximum of 1024 elements completes in full.
- R6: With reload set, active_o stays high from the start until the last element of the last descriptor in the chain.
- R7: When a descriptor completes, int_a_o or int_b_o is set if bit 4 or bit 5 of its configuration word is set. Writing to select 4 clears the flags whose write bits are set: bit0 clears A, bit1 clears B, bit2 clears the error flag. Flags whose write bits are clear are left unchanged.
- R8: A granted access with mem_err_i high sets err_o and makes the channel inactive. It issues no further memory requests.
- R9: Select 0 bit0 is the channel enable. While the enable is low, no new element is started. A write to select 3 with bit0 set while the enable is low and busy_o is low clears active_o. An abort written while the enable is high, or while busy_o is high, is ignored.
- R10: When either increment code is 0, no element read is issued while periph_req_i is low.
- R11: A configuration write while active_o is high does not change cfg_o. It pulses wr_busy_o for one cycle.
- R12: busy_o is high exactly while a memory request is outstanding. mem_req_o, its address and its direction stay stable until mem_gnt_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_sel_i | input | 3 | Register select: 0 enable, 1 config, 2 table base, 3 abort, 4 flag clear |
| reg_wdata_i | input | 32 | Register write data |
| periph_req_i | input | 1 | Peripheral ready for one element |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | ADDR_W | Byte address |
| mem_size_o | output | 2 | Access size code |
| mem_wdata_o | output | 32 | Write data, right aligned |
| mem_gnt_i | input | 1 | Grant, completes the access |
| mem_rdata_i | input | 32 | Read data, valid with grant |
| mem_err_i | input | 1 | Bus error, valid with grant |
| active_o | output | 1 | Channel active |
| busy_o | output | 1 | Bus access outstanding |
| cfg_o | output | 32 | Live configuration word with remaining count |
| int_a_o | output | 1 | Completion flag A |
| int_b_o | output | 1 | Completion flag B |
| err_o | output | 1 | Bus error flag |
| wr_busy_o | output | 1 | Configuration write refused |

## Verification
Some properties are checked on every cycle. A request is held steady until it is granted. An inactive channel issues no requests. A valid software start raises active, and a refused write pulses wr_busy_o. An abort during a bus access is ignored. Write data carries no bits above the element size. A normal finish leaves the count at all ones.

Other behaviour only shows up in the bench scenarios. The bench compares every granted access, in order, against a reference list built from the descriptors. This covers address arithmetic across the width and stride codes, descriptor chaining, the end-of-count behaviour at 1024 elements, peripheral pacing, the error stop and abort sequencing.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

  localparam int unsigned WORD_W  = 32;
  localparam int unsigned CNT_W   = 10;
  localparam int unsigned SEL_W   = 3;
  localparam int unsigned N_FLAGS = 3;

  localparam logic [SEL_W-1:0] SEL_CTRL  = 3'd0;
  localparam logic [SEL_W-1:0] SEL_CFG   = 3'd1;
  localparam logic [SEL_W-1:0] SEL_BASE  = 3'd2;
  localparam logic [SEL_W-1:0] SEL_ABORT = 3'd3;
  localparam logic [SEL_W-1:0] SEL_FLAGS = 3'd4;

  typedef struct packed {
    logic [5:0]       rsv_hi;
    logic [CNT_W-1:0] count;
    logic [1:0]       dst_inc;
    logic [1:0]       src_inc;
    logic [1:0]       rsv_mid;
    logic [1:0]       width;
    logic [1:0]       rsv_lo;
    logic             int_b;
    logic             int_a;
    logic             clr_trig;
    logic             sw_trig;
    logic             reload;
    logic             valid;
  } xfer_cfg_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_NEXT, ST_RD, ST_WR
  } chan_state_e;

  function automatic logic [WORD_W-1:0] width_mask(input logic [1:0] w);
    case (w)
      2'd0:    width_mask = 32'h0000_00FF;
      2'd1:    width_mask = 32'h0000_FFFF;
      default: width_mask = 32'hFFFF_FFFF;
    endcase
  endfunction

endpackage

// File: rtl/dma_chan_side.sv
module dma_chan_side
  import dma_chan_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic [1:0]        width_i,
  input  logic [1:0]        inc_i,
  input  logic [CNT_W-1:0]  count_i,
  output logic [ADDR_W-1:0] stride_o,
  output logic [ADDR_W-1:0] offset_o
);
  // log2(inc elements) + log2(element bytes)
  logic [2:0] shift;

  always_comb begin
    shift = {1'b0, width_i} + {1'b0, inc_i} - 3'd1;
    if (inc_i == 2'd0) begin
      stride_o = '0;
      offset_o = '0;
    end else begin
      stride_o = ADDR_W'(1) << shift;
      offset_o = ADDR_W'(count_i) << shift;
    end
  end
endmodule

// File: rtl/dma_chan_flags.sv
module dma_chan_flags
  import dma_chan_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_FLAGS-1:0] set_i,
  input  logic [N_FLAGS-1:0] clr_i,
  output logic [N_FLAGS-1:0] flags_o
);
  for (genvar g = 0; g < N_FLAGS; g++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        flags_o[g] <= 1'b0;
      else if (set_i[g])  flags_o[g] <= 1'b1;
      else if (clr_i[g])  flags_o[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/dma_chan_engine.sv
module dma_chan_engine
  import dma_chan_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic [2:0]        reg_sel_i,
  input  logic [31:0]       reg_wdata_i,
  input  logic              periph_req_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [1:0]        mem_size_o,
  output logic [31:0]       mem_wdata_o,
  input  logic              mem_gnt_i,
  input  logic [31:0]       mem_rdata_i,
  input  logic              mem_err_i,
  output logic              active_o,
  output logic              busy_o,
  output logic [31:0]       cfg_o,
  output logic              int_a_o,
  output logic              int_b_o,
  output logic              err_o,
  output logic              wr_busy_o
);
  localparam logic [ADDR_W-1:0] ALIGN_MASK = ~ADDR_W'(15);

  chan_state_e       state_q;
  xfer_cfg_t         cfg_q, wcfg;
  logic              en_q, wr_busy_q;
  logic [ADDR_W-1:0] base_q, desc_q, link_q, src_q, dst_q;
  logic [1:0]        fidx_q;
  logic [31:0]       data_q;
  logic [ADDR_W-1:0] rd_word;

  logic [1:0]        side_inc  [2];
  logic [ADDR_W-1:0] side_strd [2];
  logic [ADDR_W-1:0] side_off  [2];

  logic cfg_wr, start, abort_ok, accept, last_elem, periph_side, elem_done;
  logic [N_FLAGS-1:0] flag_set, flag_clr, flags;

  assign side_inc[0] = cfg_q.src_inc;
  assign side_inc[1] = cfg_q.dst_inc;

  for (genvar g = 0; g < 2; g++) begin : g_side
    dma_chan_side #(.ADDR_W(ADDR_W)) i_side (
      .width_i  (cfg_q.width),
      .inc_i    (side_inc[g]),
      .count_i  (cfg_q.count),
      .stride_o (side_strd[g]),
      .offset_o (side_off[g])
    );
  end

  assign wcfg        = xfer_cfg_t'(reg_wdata_i);
  assign rd_word     = mem_rdata_i[ADDR_W-1:0];
  assign active_o    = (state_q != ST_IDLE);
  assign mem_req_o   = (state_q == ST_FETCH) || (state_q == ST_RD) || (state_q == ST_WR);
  assign busy_o      = mem_req_o;
  assign mem_we_o    = (state_q == ST_WR);
  assign mem_size_o  = (state_q == ST_FETCH) ? 2'd2 : cfg_q.width;
  assign mem_wdata_o = data_q;
  assign cfg_o       = cfg_q;
  assign wr_busy_o   = wr_busy_q;

  always_comb begin
    case (state_q)
      ST_FETCH: mem_addr_o = desc_q + ADDR_W'({fidx_q, 2'b00});
      ST_WR:    mem_addr_o = dst_q;
      default:  mem_addr_o = src_q;
    endcase
  end

  assign cfg_wr      = reg_wr_i && (reg_sel_i == SEL_CFG);
  assign start       = cfg_wr && !active_o && wcfg.valid && wcfg.sw_trig;
  assign abort_ok    = reg_wr_i && (reg_sel_i == SEL_ABORT) && reg_wdata_i[0] && !en_q && !busy_o;
  assign accept      = mem_req_o && mem_gnt_i;
  assign last_elem   = (cfg_q.count == '0);
  assign periph_side = (cfg_q.src_inc == 2'd0) || (cfg_q.dst_inc == 2'd0);
  assign elem_done   = accept && !mem_err_i && (state_q == ST_WR) && last_elem;

  assign flag_set = {accept && mem_err_i, elem_done && cfg_q.int_b, elem_done && cfg_q.int_a};
  assign flag_clr = (reg_wr_i && reg_sel_i == SEL_FLAGS) ? reg_wdata_i[N_FLAGS-1:0] : '0;

  dma_chan_flags i_flags (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (flag_set),
    .clr_i   (flag_clr),
    .flags_o (flags)
  );
  assign int_a_o = flags[0];
  assign int_b_o = flags[1];
  assign err_o   = flags[2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      cfg_q     <= '0;
      en_q      <= 1'b0;
      wr_busy_q <= 1'b0;
      base_q    <= '0;
      desc_q    <= '0;
      link_q    <= '0;
      src_q     <= '0;
      dst_q     <= '0;
      fidx_q    <= '0;
      data_q    <= '0;
    end else begin
      wr_busy_q <= cfg_wr && active_o;
      if (reg_wr_i && reg_sel_i == SEL_CTRL) en_q   <= reg_wdata_i[0];
      if (reg_wr_i && reg_sel_i == SEL_BASE) base_q <= reg_wdata_i[ADDR_W-1:0] & ALIGN_MASK;
      if (cfg_wr && !active_o) cfg_q <= wcfg;

      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            desc_q  <= base_q;
            fidx_q  <= 2'd1;
            state_q <= ST_FETCH;
          end
        end
        ST_FETCH: begin
          if (accept) begin
            if (mem_err_i) state_q <= ST_IDLE;
            else begin
              case (fidx_q)
                2'd0:    cfg_q  <= xfer_cfg_t'(mem_rdata_i);
                2'd1:    src_q  <= rd_word - side_off[0];
                2'd2:    dst_q  <= rd_word - side_off[1];
                default: link_q <= rd_word & ALIGN_MASK;
              endcase
              fidx_q <= fidx_q + 2'd1;
              if (fidx_q == 2'd3) state_q <= ST_NEXT;
            end
          end
        end
        ST_NEXT: begin
          if (abort_ok) state_q <= ST_IDLE;
          else if (en_q && (!periph_side || periph_req_i)) state_q <= ST_RD;
        end
        ST_RD: begin
          if (accept) begin
            if (mem_err_i) state_q <= ST_IDLE;
            else begin
              data_q  <= mem_rdata_i & width_mask(cfg_q.width);
              state_q <= ST_WR;
            end
          end
        end
        ST_WR: begin
          if (accept) begin
            if (mem_err_i) state_q <= ST_IDLE;
            else begin
              cfg_q.count <= cfg_q.count - 1'b1;  // wraps to all ones after the last element
              src_q       <= src_q + side_strd[0];
              dst_q       <= dst_q + side_strd[1];
              if (!last_elem)        state_q <= ST_NEXT;
              else if (cfg_q.reload) begin
                desc_q  <= link_q;
                fidx_q  <= 2'd0;
                state_q <= ST_FETCH;
              end else               state_q <= ST_IDLE;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dma_chan_checker.sv
module dma_chan_checker
  import dma_chan_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_wr_i,
  input logic [2:0]        reg_sel_i,
  input logic [31:0]       reg_wdata_i,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [1:0]        mem_size_o,
  input logic [31:0]       mem_wdata_o,
  input logic              mem_gnt_i,
  input logic              mem_err_i,
  input logic              active_o,
  input logic              busy_o,
  input logic [31:0]       cfg_o,
  input logic              err_o,
  input logic              wr_busy_o
);
  a_r12_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_gnt_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o));

  a_r9_quiet_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_o |-> !mem_req_o);

  a_r1_sw_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_wr_i && reg_sel_i == SEL_CFG && !active_o && reg_wdata_i[0] && reg_wdata_i[2]
    |=> active_o);

  a_r11_busy_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_wr_i && reg_sel_i == SEL_CFG && active_o |=> wr_busy_o);

  a_r9_abort_while_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_wr_i && reg_sel_i == SEL_ABORT && busy_o && !mem_gnt_i |=> active_o);

  a_r4_wdata_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_we_o |-> (mem_wdata_o & ~width_mask(mem_size_o)) == '0);

  a_r5_done_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(active_o) && !err_o && !$past(reg_wr_i && reg_sel_i == SEL_ABORT)
    |-> cfg_o[25:16] == 10'h3FF);

  a_r8_err_stops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_gnt_i && mem_err_i |=> !active_o && err_o);
endmodule

bind dma_chan_engine dma_chan_checker #(.ADDR_W(ADDR_W)) i_dma_chan_checker (.*);

// File: tb/test_dma_chan_engine.sv
module test_dma_chan_engine;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        reg_wr = 0, periph_req = 0, gnt = 0, merr = 0;
  logic [2:0]  reg_sel = 0;
  logic [31:0] reg_wdata = 0, rdata = 0;
  logic        mem_req, mem_we, active, busy, int_a, int_b, err, wr_busy;
  logic [31:0] mem_addr, mem_wdata, cfg;
  logic [1:0]  mem_size;

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;
  logic [31:0] err_addr = 32'hFFFF_FFF0;

  typedef struct { bit we; logic [31:0] addr; logic [1:0] size; logic [31:0] data; int kind; } txn_t;
  txn_t exp_q[$];
  logic [31:0] mem [logic [31:0]];

  dma_chan_engine i_dma_chan_engine (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(reg_wr), .reg_sel_i(reg_sel), .reg_wdata_i(reg_wdata),
    .periph_req_i(periph_req), .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_size_o(mem_size), .mem_wdata_o(mem_wdata), .mem_gnt_i(gnt), .mem_rdata_i(rdata),
    .mem_err_i(merr), .active_o(active), .busy_o(busy), .cfg_o(cfg), .int_a_o(int_a),
    .int_b_o(int_b), .err_o(err), .wr_busy_o(wr_busy));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] mem_rd(logic [31:0] a);
    return mem.exists(a) ? mem[a] : (a * 32'h9E37_79B1) ^ 32'h5A5A_0000;
  endfunction

  function automatic logic [31:0] wmask(logic [1:0] w);
    return (w == 0) ? 32'hFF : (w == 1) ? 32'hFFFF : 32'hFFFF_FFFF;
  endfunction

  function automatic logic [31:0] mk_cfg(bit v, bit rl, bit sw, bit ia, bit ib,
                                         int w, int si, int di, int cnt);
    return {6'd0, 10'(cnt), 2'(di), 2'(si), 2'd0, 2'(w), 2'd0, ib, ia, 1'b0, sw, rl, v};
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  function automatic void push(bit we, logic [31:0] a, logic [1:0] sz, logic [31:0] d, int k);
    txn_t t;
    t.we = we; t.addr = a; t.size = sz; t.data = d; t.kind = k;
    exp_q.push_back(t);
  endfunction

  // reference: expected access list from the descriptors in bench memory
  function automatic void plan(logic [31:0] base, logic [31:0] c0);
    logic [31:0] desc = base, c = c0;
    bit first = 1;
    forever begin
      int cnt, w, sb, db;
      logic [31:0] s, d;
      if (!first) begin
        push(0, desc, 2, 0, 0);
        c = mem_rd(desc);
      end
      push(0, desc + 4, 2, 0, 0);
      push(0, desc + 8, 2, 0, 0);
      push(0, desc + 12, 2, 0, 0);
      cnt = int'(c[25:16]); w = int'(c[9:8]);
      sb = (c[13:12] == 0) ? 0 : (1 << (int'(c[13:12]) - 1)) * (1 << w);
      db = (c[15:14] == 0) ? 0 : (1 << (int'(c[15:14]) - 1)) * (1 << w);
      s = mem_rd(desc + 4) - 32'(sb * cnt);
      d = mem_rd(desc + 8) - 32'(db * cnt);
      for (int e = 0; e <= cnt; e++) begin
        push(0, s, 2'(w), 0, 1);
        push(1, d, 2'(w), mem_rd(s) & wmask(2'(w)), 2);
        s += 32'(sb); d += 32'(db);
      end
      if (!c[1]) break;
      desc = mem_rd(desc + 12) & ~32'hF;
      first = 0;
    end
  endfunction

  // memory responder with stalls, compares each granted access
  initial begin
    forever begin
      @(negedge clk);
      gnt = 0; merr = 0; cyc++;
      if (rst_n && mem_req && (cyc % 3 != 0)) begin
        txn_t t;
        gnt = 1;
        if (exp_q.size() == 0) check(0, "R9 unexpected request", mem_addr, 0);
        else begin
          t = exp_q.pop_front();
          case (t.kind)
            0: check(!mem_we && mem_addr == t.addr && mem_size == t.size, "R2 fetch", mem_addr, t.addr);
            1: check(!mem_we && mem_addr == t.addr && mem_size == t.size, "R3 read", mem_addr, t.addr);
            default: check(mem_we && mem_addr == t.addr && mem_wdata == t.data && mem_size == t.size,
                           "R4 write", mem_wdata, t.data);
          endcase
        end
        rdata = mem_rd(mem_addr);
        if (mem_addr == err_addr && !mem_we) merr = 1;
        if (mem_we) mem[mem_addr] = mem_wdata;
      end
    end
  end

  task automatic wr(logic [2:0] s, logic [31:0] d);
    reg_wr = 1; reg_sel = s; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic start(logic [31:0] base, logic [31:0] s_end, logic [31:0] d_end,
                       logic [31:0] link, logic [31:0] c);
    mem[base + 4] = s_end; mem[base + 8] = d_end; mem[base + 12] = link;
    wr(3'd2, base);
    plan(base, c);
    wr(3'd1, c);
  endtask

  task automatic wait_idle(string req);
    int n = 0;
    while (active && n < 20000) begin @(negedge clk); n++; end
    check(!active && exp_q.size() == 0, req, exp_q.size(), 0);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(!active && !busy && !mem_req && !int_a && !int_b && !err && cfg == 0,
          "R12 reset state", {active, busy, int_a, int_b, err}, 0);
    wr(3'd0, 1);

    // R1 R3 R5 R7: word copy, flag A
    start(32'h1000, 32'h2000 + 12, 32'h4000 + 12, 0, mk_cfg(1,0,1,1,0, 2,1,1, 3));
    check(active, "R1 start", active, 1);
    wait_idle("R3 word copy complete");
    check(cfg[25:16] == 10'h3FF, "R5 count all ones", cfg[25:16], 10'h3FF);
    check(int_a && !int_b, "R7 flag A only", {int_a, int_b}, 2'b10);

    // R3 R4: byte elements, source stride 2, destination stride 4, flag B
    start(32'h1100, 32'h2100 + 8, 32'h4100 + 16, 0, mk_cfg(1,0,1,0,1, 0,2,3, 4));
    wait_idle("R3 strided bytes complete");
    check(int_b, "R7 flag B", int_b, 1);

    // R7 write-one-to-clear, A only
    wr(3'd4, 32'h1);
    check(!int_a && int_b, "R7 clear A keeps B", {int_a, int_b}, 2'b01);
    wr(3'd4, 32'h2);
    check(!int_b, "R7 clear B", int_b, 0);

    // R6 R2: two-descriptor chain
    mem[32'h3000] = mk_cfg(1,0,0,1,0, 2,3,1, 1);
    mem[32'h3004] = 32'h2300 + 16; mem[32'h3008] = 32'h4300 + 4; mem[32'h300C] = 0;
    start(32'h1200, 32'h2200 + 4, 32'h4200 + 4, 32'h3000, mk_cfg(1,1,1,0,0, 1,1,1, 2));
    wait_idle("R6 chain runs to end with active held");
    check(int_a && cfg[25:16] == 10'h3FF, "R6 second descriptor completes", cfg, 32'h03FF_0000);
    wr(3'd4, 32'h7);

    // R1 valid without software start
    wr(3'd1, mk_cfg(1,0,0,0,0, 2,1,1, 7));
    @(negedge clk);
    check(!active && !mem_req, "R1 no start without sw bit", active, 0);
    check(cfg[25:16] == 10'd7, "R5 count readback", cfg[25:16], 7);

    // R10 peripheral pacing, source held fixed
    periph_req = 0;
    start(32'h1300, 32'h2400, 32'h4400 + 12, 0, mk_cfg(1,0,1,0,0, 2,0,1, 3));
    repeat (30) @(negedge clk);
    check(active && exp_q.size() == 8, "R10 no element without request", exp_q.size(), 8);
    periph_req = 1;
    wait_idle("R10 paced transfer complete");
    periph_req = 0;

    // R8 bus error on the second element read
    err_addr = 32'h2500 + 4;
    start(32'h1400, 32'h2500 + 12, 32'h4500 + 12, 0, mk_cfg(1,0,1,1,0, 2,1,1, 3));
    begin
      int n = 0;
      while (active && n < 1000) begin @(negedge clk); n++; end
    end
    check(err && !active && !int_a, "R8 error stops channel", {err, active}, 2'b10);
    exp_q.delete();
    repeat (5) @(negedge clk);
    check(!mem_req, "R8 no request after error", mem_req, 0);
    err_addr = 32'hFFFF_FFF0;
    wr(3'd4, 32'h4);

    // R9 R11 abort sequence on a long transfer
    start(32'h1500, 32'h6000 + 800, 32'h8000 + 800, 0, mk_cfg(1,0,1,0,0, 2,1,1, 200));
    repeat (20) @(negedge clk);
    wr(3'd1, mk_cfg(1,0,1,0,0, 2,1,1, 5));
    check(wr_busy, "R11 write refused pulse", wr_busy, 1);
    check(cfg[25:16] > 10'd100, "R11 config unchanged", cfg[25:16], 200);
    wr(3'd3, 1);
    @(negedge clk);
    check(active, "R9 abort ignored while enabled", active, 1);
    wr(3'd0, 0);
    while (busy) @(negedge clk);
    wr(3'd3, 1);
    check(!active, "R9 abort clears active", active, 0);
    exp_q.delete();
    repeat (10) @(negedge clk);
    check(!mem_req && !active, "R9 channel quiet after abort", mem_req, 0);
    wr(3'd0, 1);

    // R5 maximum count, 1024 byte elements
    start(32'h1600, 32'h1_0000 + 1023, 32'h2_0000 + 1023, 0, mk_cfg(1,0,1,1,0, 0,1,1, 1023));
    wait_idle("R5 1024 elements complete");
    check(cfg[25:16] == 10'h3FF && int_a, "R5 max count finish", cfg[25:16], 10'h3FF);

    summary();
  end
endmodule